// File: doc/BRIEF.md
# Branch Opcode Classifier

This block sorts one recorded control-flow transfer into a class. It takes the leading opcode byte, the byte after a 0x0F escape, the ModRM byte, the privilege level of the source and of the target address, an abort flag, and two flags that say whether the recorded source or target address is zero. The opcode bytes arrive already aligned: prefix stripping and instruction-length decoding happen upstream.

The result is a 13-bit mask. At most one class bit is set, and next to it is exactly one privilege bit, which is taken from the target. An all-zero mask means that the transfer could not be classified. Two things can override the opcode class. An abort flag reports an aborted transaction whatever the opcode is. A transfer from user level into the kernel is reported as an asynchronous interrupt or trap, unless the opcode is itself a system call or a software interrupt. A branch-record filter compares this mask against a wanted-class mask and drops the entries that do not match.

A parameter chooses between a purely combinational decoder and one with a single registered output stage.

Top module: `branch_class_decoder`

## Requirements
- R1: When the first opcode byte is 0x0F, the second byte selects the class. 0x05 or 0x34 gives syscall (bit 4). 0x07 or 0x35 gives sysret (bit 5). 0x80 to 0x8F gives conditional (bit 8). Any other second byte gives no class.
- R2: The one-byte opcodes 0x70 to 0x7F and 0xE0 to 0xE3 give conditional (bit 8).
- R3: 0xC2, 0xC3, 0xCA and 0xCB give return (bit 3). 0xCF gives interrupt return (bit 7). 0xCC to 0xCE give software interrupt (bit 6).
- R4: 0xE8 and 0x9A give call (bit 2). 0xE9 to 0xEB give jump (bit 9).
- R5: For opcode 0xFF the class comes from ModRM bits [5:3]. A value of 2 or 3 gives indirect call (bit 11). A value of 4 or 5 gives jump (bit 9). Any other value gives no class.
- R6: Every opcode not listed in R1 to R5 gives no class. When no override applies, the mask is then all zero.
- R7: If the source-zero flag or the target-zero flag is set, the mask is all zero. This holds even when the abort flag is set.
- R8: If both addresses are nonzero and the abort flag is set, the mask is abort (bit 12) plus the target privilege bit, whatever the opcode bytes are.
- R9: If the source is user level (src_kernel=0) and the target is kernel level (dst_kernel=1), and there is no zero address and no abort, then any class other than syscall or software interrupt becomes hardware interrupt/trap (bit 10). This includes the case of no class.
- R10: In every nonzero mask exactly one of bits [12:2] is set. Bit 0 (user) is set when dst_kernel=0, and bit 1 (kernel) is set when dst_kernel=1. An all-zero mask carries no privilege bit.
- R11: With REGISTERED=1 (the default), class_mask shows the class of the inputs sampled at the previous rising clock edge. While rst_n is low, class_mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Active-low reset of the output register |
| op_first | input | 8 | First opcode byte |
| op_second | input | 8 | Opcode byte after a 0x0F escape |
| modrm | input | 8 | ModRM byte; only bits [5:3] are used |
| src_kernel | input | 1 | Source address is at kernel level |
| dst_kernel | input | 1 | Target address is at kernel level |
| abort_flag | input | 1 | The recorded transfer was a transaction abort |
| src_zero | input | 1 | The recorded source address is zero |
| dst_zero | input | 1 | The recorded target address is zero |
| class_mask | output | 13 | Bit 0 user, bit 1 kernel, bits 2..12 the class |

## Verification
The hardest cases to reach are the ones where the rules stack on top of each other. One is an escape byte followed by an unknown second byte on a user-to-kernel transfer, which must come out as hardware interrupt and not as none. Another is an abort whose address is zero, where the zero rule must win. The stimulus reaches these with directed groups. Each group walks every first byte, every escaped second byte and every ModRM value, and then repeats a fixed set of opcodes under all four privilege pairings and all abort and zero-flag combinations. After that, a pseudo-random phase biased towards 0x0F and 0xFF mixes all the rules. Every output is compared on each clock with a behavioural model in the bench.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   localparam int CLS_W      = 13;
   localparam int B_USER     = 0;
   localparam int B_KERNEL   = 1;
   localparam int B_CALL     = 2;
   localparam int B_RET      = 3;
   localparam int B_SYSCALL  = 4;
   localparam int B_SYSRET   = 5;
   localparam int B_SWINT    = 6;
   localparam int B_IRET     = 7;
   localparam int B_COND     = 8;
   localparam int B_JUMP     = 9;
   localparam int B_HWIRQ    = 10;
   localparam int B_INDCALL  = 11;
   localparam int B_ABORT    = 12;
   localparam int REG_LSB    = 3;
   localparam int REG_W      = 3;

   typedef logic [CLS_W-1:0] cls_mask_t;

   function automatic cls_mask_t cls_bit(input int pos);
      cls_mask_t m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/bcd_opcode_decode.sv
module bcd_opcode_decode
   import bcd_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0]  op_first,
   input  logic [OP_W-1:0]  op_second,
   input  logic [REG_W-1:0] modrm_reg,
   output cls_mask_t        raw_cls
);
   always_comb begin
      raw_cls = '0;
      case (op_first) inside
         8'h0F: begin
            case (op_second) inside
               8'h05, 8'h34:   raw_cls = cls_bit(B_SYSCALL);
               8'h07, 8'h35:   raw_cls = cls_bit(B_SYSRET);
               [8'h80:8'h8F]:  raw_cls = cls_bit(B_COND);
               default:        raw_cls = '0;
            endcase
         end
         [8'h70:8'h7F], [8'hE0:8'hE3]: raw_cls = cls_bit(B_COND);
         8'hC2, 8'hC3, 8'hCA, 8'hCB:   raw_cls = cls_bit(B_RET);
         8'hCF:                        raw_cls = cls_bit(B_IRET);
         [8'hCC:8'hCE]:                raw_cls = cls_bit(B_SWINT);
         8'hE8, 8'h9A:                 raw_cls = cls_bit(B_CALL);
         [8'hE9:8'hEB]:                raw_cls = cls_bit(B_JUMP);
         8'hFF: begin
            case (modrm_reg)
               3'd2, 3'd3: raw_cls = cls_bit(B_INDCALL);
               3'd4, 3'd5: raw_cls = cls_bit(B_JUMP);
               default:    raw_cls = '0;
            endcase
         end
         default: raw_cls = '0;
      endcase
   end
endmodule

// File: rtl/bcd_ring_fixup.sv
module bcd_ring_fixup
   import bcd_pkg::*;
(
   input  cls_mask_t raw_cls,
   input  logic      src_kernel,
   input  logic      dst_kernel,
   input  logic      abort_flag,
   input  logic      src_zero,
   input  logic      dst_zero,
   output cls_mask_t final_cls
);
   cls_mask_t cls_ovr;
   cls_mask_t plm;
   logic      enters_kernel;
   logic      sync_entry;

   assign enters_kernel = !src_kernel && dst_kernel;
   assign sync_entry    = raw_cls[B_SYSCALL] || raw_cls[B_SWINT];
   assign plm           = dst_kernel ? cls_bit(B_KERNEL) : cls_bit(B_USER);

   always_comb begin
      cls_ovr = raw_cls;
      if (enters_kernel && !sync_entry)
         cls_ovr = cls_bit(B_HWIRQ);
      if (abort_flag)
         cls_ovr = cls_bit(B_ABORT);
      if (src_zero || dst_zero)
         final_cls = '0;
      else if (|cls_ovr)
         final_cls = cls_ovr | plm;
      else
         final_cls = '0;
   end
endmodule

// File: rtl/branch_class_decoder.sv
module branch_class_decoder
   import bcd_pkg::*;
#(
   parameter int OP_W       = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] op_first,
   input  logic [OP_W-1:0] op_second,
   input  logic [OP_W-1:0] modrm,
   input  logic            src_kernel,
   input  logic            dst_kernel,
   input  logic            abort_flag,
   input  logic            src_zero,
   input  logic            dst_zero,
   output logic [CLS_W-1:0] class_mask
);
   localparam int REG_MSB = REG_LSB + REG_W - 1;

   if (OP_W != 8) begin : g_bad_width
      $error("branch_class_decoder: opcode values are byte codes, OP_W must be 8");
   end
   if (REG_MSB >= OP_W) begin : g_bad_field
      $error("branch_class_decoder: ModRM reg field exceeds byte");
   end

   cls_mask_t raw_cls;
   cls_mask_t next_cls;
   logic      unused_modrm_bits;

   assign unused_modrm_bits = ^{modrm[OP_W-1:REG_MSB+1], modrm[REG_LSB-1:0]};

   bcd_opcode_decode #(.OP_W(OP_W)) u_decode (
      .op_first  (op_first),
      .op_second (op_second),
      .modrm_reg (modrm[REG_MSB:REG_LSB]),
      .raw_cls   (raw_cls)
   );

   bcd_ring_fixup u_fixup (
      .raw_cls    (raw_cls),
      .src_kernel (src_kernel),
      .dst_kernel (dst_kernel),
      .abort_flag (abort_flag),
      .src_zero   (src_zero),
      .dst_zero   (dst_zero),
      .final_cls  (next_cls)
   );

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) class_mask <= '0;
         else        class_mask <= next_cls;
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign class_mask     = next_cls;
   end
endmodule

// File: rtl/branch_class_decoder_checker.sv
module branch_class_decoder_checker
   import bcd_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            src_kernel,
   input logic            dst_kernel,
   input logic            abort_flag,
   input logic            src_zero,
   input logic            dst_zero,
   input logic [CLS_W-1:0] class_mask
);
   logic d_sk, d_dk, d_ab, d_sz, d_dz;

   if (REGISTERED) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_sk <= 1'b0; d_dk <= 1'b0; d_ab <= 1'b0;
            d_sz <= 1'b1; d_dz <= 1'b1;
         end else begin
            d_sk <= src_kernel; d_dk <= dst_kernel; d_ab <= abort_flag;
            d_sz <= src_zero;   d_dz <= dst_zero;
         end
      end
   end else begin : g_now
      assign d_sk = src_kernel;
      assign d_dk = dst_kernel;
      assign d_ab = abort_flag;
      assign d_sz = src_zero;
      assign d_dz = dst_zero;
   end

   p_one_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(class_mask[B_ABORT:B_CALL]));

   p_one_plm_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|class_mask) |-> ($countones(class_mask[B_KERNEL:B_USER]) == 1 &&
                         class_mask[B_KERNEL] == d_dk));

   p_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (d_sz || d_dz) |-> (class_mask == '0));

   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!d_sz && !d_dz && d_ab) |-> (class_mask[B_ABORT] &&
                                    class_mask[B_INDCALL:B_CALL] == '0));

   p_ring_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!d_sz && !d_dz && !d_ab && !d_sk && d_dk) |->
         (class_mask[B_HWIRQ] || class_mask[B_SYSCALL] || class_mask[B_SWINT]));
endmodule

bind branch_class_decoder branch_class_decoder_checker #(.REGISTERED(REGISTERED)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_kernel (src_kernel),
   .dst_kernel (dst_kernel),
   .abort_flag (abort_flag),
   .src_zero   (src_zero),
   .dst_zero   (dst_zero),
   .class_mask (class_mask)
);

// File: tb/branch_class_decoder_bench.sv
module branch_class_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_first = 8'h00, op_second = 8'h00, modrm = 8'h00;
   logic        src_kernel = 1'b0, dst_kernel = 1'b0, abort_flag = 1'b0;
   logic        src_zero = 1'b0, dst_zero = 1'b0;
   logic [12:0] class_mask;

   int          checks = 0;
   int          errors = 0;
   logic [12:0] exp_prev = '0;
   string       tag_prev = "";
   bit          have_prev = 0;
   logic [31:0] lfsr = 32'hACE1_2468;

   always #2 clk = ~clk;

   branch_class_decoder u_branch_class_decoder (
      .clk(clk), .rst_n(rst_n), .op_first(op_first), .op_second(op_second),
      .modrm(modrm), .src_kernel(src_kernel), .dst_kernel(dst_kernel),
      .abort_flag(abort_flag), .src_zero(src_zero), .dst_zero(dst_zero),
      .class_mask(class_mask));

   function automatic logic [12:0] ref_class(input int b0, input int b1, input int mr,
                                             input bit sk, input bit dk, input bit ab,
                                             input bit sz, input bit dz, output string tag);
      int k;
      int rf;
      k  = -1;
      rf = (mr >> 3) & 7;
      if (sz || dz) begin tag = "R7"; return '0; end
      if (ab) begin tag = "R8"; return 13'h1000 | (dk ? 13'd2 : 13'd1); end
      if (b0 == 8'h0F) begin
         tag = "R1";
         if (b1 == 8'h05 || b1 == 8'h34) k = 4;
         else if (b1 == 8'h07 || b1 == 8'h35) k = 5;
         else if (b1 >= 8'h80 && b1 <= 8'h8F) k = 8;
      end else if ((b0 >= 8'h70 && b0 <= 8'h7F) || (b0 >= 8'hE0 && b0 <= 8'hE3)) begin
         tag = "R2"; k = 8;
      end else if (b0 == 8'hC2 || b0 == 8'hC3 || b0 == 8'hCA || b0 == 8'hCB) begin
         tag = "R3"; k = 3;
      end else if (b0 == 8'hCF) begin
         tag = "R3"; k = 7;
      end else if (b0 >= 8'hCC && b0 <= 8'hCE) begin
         tag = "R3"; k = 6;
      end else if (b0 == 8'hE8 || b0 == 8'h9A) begin
         tag = "R4"; k = 2;
      end else if (b0 >= 8'hE9 && b0 <= 8'hEB) begin
         tag = "R4"; k = 9;
      end else if (b0 == 8'hFF) begin
         tag = "R5";
         if (rf == 2 || rf == 3) k = 11;
         else if (rf == 4 || rf == 5) k = 9;
      end else begin
         tag = "R6";
      end
      if (!sk && dk && k != 4 && k != 6) begin k = 10; tag = "R9"; end
      if (k < 0) return '0;
      return (13'd1 << k) | (dk ? 13'd2 : 13'd1);
   endfunction

   task automatic check_out(input logic [12:0] exp, input string tag);
      checks++;
      if (class_mask !== exp) begin
         errors++;
         $display("FAIL %s: class_mask got %h expected %h", tag, class_mask, exp);
      end
      if (exp != '0) begin
         checks++;
         if (class_mask[1:0] !== exp[1:0]) begin
            errors++;
            $display("FAIL R10: privilege bits got %b expected %b", class_mask[1:0], exp[1:0]);
         end
      end
   endtask

   task automatic apply(input int b0, input int b1, input int mr, input bit sk,
                        input bit dk, input bit ab, input bit sz, input bit dz);
      @(negedge clk);
      if (have_prev) check_out(exp_prev, tag_prev);
      op_first = 8'(b0); op_second = 8'(b1); modrm = 8'(mr);
      src_kernel = sk; dst_kernel = dk; abort_flag = ab; src_zero = sz; dst_zero = dz;
      exp_prev  = ref_class(b0, b1, mr, sk, dk, ab, sz, dz, tag_prev);
      have_prev = 1;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int sel[6];
      sel = '{8'h0F, 8'hCD, 8'h74, 8'hC3, 8'h90, 8'hFF};
      // R11: output held at zero in reset, even with a classifiable input
      op_first = 8'hE8; dst_kernel = 1'b1; src_kernel = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_out('0, "R11");
      end
      rst_n = 1'b1;
      @(negedge clk);
      check_out(13'h0006, "R4");
      // R11: new input does not show before the next rising edge
      op_first = 8'hC3;
      #1 check_out(13'h0006, "R11");
      @(negedge clk);
      check_out(13'h000A, "R11");
      // every first byte, user to user
      for (int b = 0; b < 256; b++) apply(b, 8'h05, 8'h10, 0, 0, 0, 0, 0);
      // every escaped byte, kernel to kernel
      for (int b = 0; b < 256; b++) apply(8'h0F, b, 0, 1, 1, 0, 0, 0);
      // every ModRM for 0xFF, both same-level pairings
      for (int m = 0; m < 256; m++) apply(8'hFF, 0, m, m[0], m[0], 0, 0, 0);
      // privilege pairings, abort and zero flags over a fixed set
      for (int s = 0; s < 6; s++)
         for (int v = 0; v < 32; v++)
            apply(sel[s], (s == 0) ? ((v & 1) ? 8'h34 : 8'h00) : 8'h00, 8'h18,
                  v[0], v[1], v[2], v[3], v[4]);
      // escape with unknown second byte entering kernel: hardware interrupt
      apply(8'h0F, 8'h00, 0, 0, 1, 0, 0, 0);
      apply(8'h0F, 8'h05, 0, 0, 1, 0, 0, 0);
      apply(8'hCC, 8'h00, 0, 0, 1, 0, 0, 0);
      apply(8'hE8, 8'h00, 0, 0, 1, 1, 1, 0);
      // mixed pseudo-random phase
      for (int n = 0; n < 3000; n++) begin
         int b0;
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         b0 = (lfsr[3:0] == 4'd0) ? 8'h0F : (lfsr[3:0] == 4'd1) ? 8'hFF : int'(lfsr[31:24]);
         apply(b0, int'(lfsr[23:16]), int'(lfsr[15:8]), lfsr[4], lfsr[5],
               lfsr[9:6] == 4'd0, lfsr[13:10] == 4'd0, lfsr[17:14] == 4'd0);
      end
      @(negedge clk);
      check_out(exp_prev, tag_prev);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule